// File: doc/BRIEF.md
# Supply and Push-Button Reset Supervisor

This block turns two raw reset causes into one clean, active-low reset for a microcontroller subsystem. One cause is a digital under-voltage flag from an analog comparator outside the block. The other is an active-low manual reset line wired straight to a mechanical push-button. Both inputs are synchronised to a free-running clock. The under-voltage flag must stay true for a minimum number of clocks before it counts, so brief supply dips are ignored. The button line is debounced, so a level is accepted only after it has stayed stable long enough.

While either filtered cause is active, reset is asserted. When the last cause goes away, a recovery timer holds reset for a fixed number of clocks and then releases it. If a qualified cause returns during that hold, the timer clears and starts again only after the cause has gone. The local asynchronous initialisation also asserts reset, and the same recovery hold runs before the first release. The output is given twice: as a pull-low enable for an open-drain pad model, and as its logical complement.

Top module: `reset_supervisor`

## Requirements
- R1: While `arst_n` is low, reset is asserted. After `arst_n` rises, `rst_n_o` goes high on the TREC_CYCLES-th rising clock edge, provided no cause is active.
- R2: Let edge k be the first rising edge that samples `supply_low_i` high. If the flag is held high for GLITCH_CYCLES consecutive sampled edges, `rst_n_o` falls on edge k+GLITCH_CYCLES+2.
- R3: A run of fewer than GLITCH_CYCLES consecutive high samples of `supply_low_i` has no effect on the output. This holds when reset is idle, and it also holds during a recovery hold, whose release time does not move.
- R4: Reset stays asserted while a qualified under-voltage event lasts. Let edge k be the first edge that samples the flag low again. With no other cause, `rst_n_o` rises on edge k+TREC_CYCLES+2.
- R5: If a qualified under-voltage event occurs while the recovery hold is counting, the count clears. Release then happens TREC_CYCLES+2 edges after the new event's flag is first sampled low.
- R6: Let edge k be the first rising edge that samples `man_rst_ni` low. If it stays low for DEBOUNCE_CYCLES sampled edges, `rst_n_o` falls on edge k+DEBOUNCE_CYCLES+2, and reset stays asserted as long as the line stays low.
- R7: A level change on `man_rst_ni` that lasts fewer than DEBOUNCE_CYCLES sampled edges is ignored, whether it is a press or a release (contact bounce).
- R8: Let edge k be the first edge that samples a release of `man_rst_ni` (high) that then stays stable. With no other cause, `rst_n_o` rises on edge k+DEBOUNCE_CYCLES+TREC_CYCLES+1.
- R9: When both causes overlap, reset stays asserted until the later one is released, and the recovery hold is then timed from that release.
- R10: `rst_drive_low_o` is 1 exactly while reset is asserted, and `rst_n_o` is always its complement.
- R11: Reset rises only from a qualified cause. With no cause active it stays deasserted for any length of time, because the recovery counter saturates and never wraps.
- R12: Every reset assertion lasts at least TREC_CYCLES clocks, counted from the cycle in which the last cause has cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| arst_n | input | 1 | Asynchronous active-low local power-on initialisation |
| supply_low_i | input | 1 | Under-voltage flag from the external comparator, 1 = supply low |
| man_rst_ni | input | 1 | Raw push-button manual reset, active low |
| rst_drive_low_o | output | 1 | 1 = pull the open-drain reset pad low |
| rst_n_o | output | 1 | Logical active-low reset level |

## Verification
The bench builds the supervisor with GLITCH_CYCLES = 4, DEBOUNCE_CYCLES = 6 and TREC_CYCLES = 20. These small values put both sides of each boundary within a few dozen clocks: dips of three and four samples, presses and releases of five and six stable samples, and a dip or press that arrives partway through a hold. Each edge of `rst_n_o` is expected on one exact cycle. A retriggered or undisturbed recovery therefore shows up as a measurable shift of the release edge, and long idle stretches check that the saturating counter never produces a spurious pulse.

// File: rtl/reset_supervisor_pkg.sv
package reset_supervisor_pkg;

    // Counter width able to hold values 0 .. n-1, never narrower than one bit.
    function automatic int span_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Qualified reset causes after filtering.
    typedef struct packed {
        logic supply_fault;
        logic button_hold;
    } rst_cause_t;

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d       = st_q;
                st_d.chain = din;
            end
        end else begin : g_chain
            always_comb begin
                st_d       = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.chain <= {STAGES{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.chain[STAGES-1];
endmodule

// File: rtl/rsup_dip_filter.sv
module rsup_dip_filter
    import reset_supervisor_pkg::*;
#(
    parameter int GLITCH_CYCLES = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic low_i,
    output logic fault_o
);
    localparam int              CW   = span_width(GLITCH_CYCLES);
    localparam logic [CW-1:0]   LAST = CW'(GLITCH_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          fault;
    } dip_state_t;

    dip_state_t st_d, st_q;

    // A fault is declared once the flag has been seen high on GLITCH_CYCLES
    // consecutive clocks; any low sample clears both run and fault.
    always_comb begin
        st_d = st_q;
        if (!low_i) begin
            st_d.run   = '0;
            st_d.fault = 1'b0;
        end else begin
            st_d.fault = st_q.fault | (st_q.run == LAST);
            if (st_q.run != LAST) begin
                st_d.run = st_q.run + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.run   <= '0;
            st_q.fault <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_o = st_q.fault;
endmodule

// File: rtl/rsup_debounce.sv
module rsup_debounce
    import reset_supervisor_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 32
) (
    input  logic clk,
    input  logic arst_n,
    input  logic btn_n_i,
    output logic hold_o
);
    localparam int            CW   = span_width(DEBOUNCE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] dwell;
        logic          level;
    } deb_state_t;

    deb_state_t st_d, st_q;

    // The accepted level follows the input only after the input has differed
    // from it for DEBOUNCE_CYCLES consecutive clocks.
    always_comb begin
        st_d = st_q;
        if (btn_n_i == st_q.level) begin
            st_d.dwell = '0;
        end else if (st_q.dwell == LAST) begin
            st_d.level = btn_n_i;
            st_d.dwell = '0;
        end else begin
            st_d.dwell = st_q.dwell + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.dwell <= '0;
            st_q.level <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = ~st_q.level;
endmodule

// File: rtl/rsup_recovery.sv
module rsup_recovery
    import reset_supervisor_pkg::*;
#(
    parameter int TREC_CYCLES = 200
) (
    input  logic       clk,
    input  logic       arst_n,
    input  rst_cause_t cause_i,
    output logic       assert_o
);
    localparam int            CW   = span_width(TREC_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(TREC_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] elapsed;
        logic          asserted;
    } rec_state_t;

    rec_state_t st_d, st_q;
    logic       any_cause;

    assign any_cause = cause_i.supply_fault | cause_i.button_hold;

    // Any live cause pins the output and clears the hold count. Once no cause
    // remains, the count climbs to LAST and the release happens on the next
    // edge. At LAST the count stays put, so an idle block never wraps.
    always_comb begin
        st_d = st_q;
        if (any_cause) begin
            st_d.elapsed  = '0;
            st_d.asserted = 1'b1;
        end else if (st_q.asserted) begin
            if (st_q.elapsed == LAST) begin
                st_d.asserted = 1'b0;
            end else begin
                st_d.elapsed = st_q.elapsed + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.elapsed  <= '0;
            st_q.asserted <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign assert_o = st_q.asserted;
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
    import reset_supervisor_pkg::*;
#(
    parameter int GLITCH_CYCLES   = 16,
    parameter int DEBOUNCE_CYCLES = 32,
    parameter int TREC_CYCLES     = 200,
    parameter int SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_low_i,
    input  logic man_rst_ni,
    output logic rst_drive_low_o,
    output logic rst_n_o
);
    logic       supply_low_s;
    logic       man_rst_s;
    logic       supply_fault;
    logic       button_hold;
    logic       hold_reset;
    rst_cause_t cause;

    rsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_supply (
        .clk    (clk),
        .arst_n (arst_n),
        .din    (supply_low_i),
        .dout   (supply_low_s)
    );

    rsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_button (
        .clk    (clk),
        .arst_n (arst_n),
        .din    (man_rst_ni),
        .dout   (man_rst_s)
    );

    rsup_dip_filter #(.GLITCH_CYCLES(GLITCH_CYCLES)) u_dip (
        .clk     (clk),
        .arst_n  (arst_n),
        .low_i   (supply_low_s),
        .fault_o (supply_fault)
    );

    rsup_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
        .clk     (clk),
        .arst_n  (arst_n),
        .btn_n_i (man_rst_s),
        .hold_o  (button_hold)
    );

    always_comb begin
        cause              = '0;
        cause.supply_fault = supply_fault;
        cause.button_hold  = button_hold;
    end

    rsup_recovery #(.TREC_CYCLES(TREC_CYCLES)) u_rec (
        .clk      (clk),
        .arst_n   (arst_n),
        .cause_i  (cause),
        .assert_o (hold_reset)
    );

    assign rst_drive_low_o = hold_reset;
    assign rst_n_o         = ~hold_reset;
endmodule

// File: rtl/reset_supervisor_chk.sv
module reset_supervisor_chk #(
    parameter int GLITCH_CYCLES = 16,
    parameter int TREC_CYCLES   = 200
) (
    input logic clk,
    input logic arst_n,
    input logic supply_low_i,
    input logic fault_i,
    input logic button_i,
    input logic rst_i
);
    int run_q;
    int hold_q;

    // Consecutive high samples of the raw supply flag (saturating).
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            run_q <= 0;
        end else if (supply_low_i) begin
            run_q <= (run_q < GLITCH_CYCLES) ? run_q + 1 : run_q;
        end else begin
            run_q <= 0;
        end
    end

    // Cycles spent asserted with no cause left.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            hold_q <= 0;
        end else if (rst_i && !(fault_i || button_i)) begin
            hold_q <= hold_q + 1;
        end else begin
            hold_q <= 0;
        end
    end

    // R4: a qualified supply fault keeps reset asserted
    p_fault_holds_r4: assert property (@(posedge clk) disable iff (!arst_n)
        fault_i |=> rst_i);

    // R6: an accepted button press keeps reset asserted
    p_button_holds_r6: assert property (@(posedge clk) disable iff (!arst_n)
        button_i |=> rst_i);

    // R12: release only after exactly the full hold with no cause
    p_min_hold_r12: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rst_i) |-> (hold_q == TREC_CYCLES));

    // R2: a fault is only declared after enough consecutive flag samples
    p_filter_len_r2: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(fault_i) |-> ($past(run_q, 2) >= GLITCH_CYCLES));

    // R11: reset only rises because of a qualified cause
    p_rise_has_cause_r11: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_i) |-> $past(fault_i || button_i));
endmodule

bind reset_supervisor reset_supervisor_chk #(
    .GLITCH_CYCLES (GLITCH_CYCLES),
    .TREC_CYCLES   (TREC_CYCLES)
) u_chk (
    .clk          (clk),
    .arst_n       (arst_n),
    .supply_low_i (supply_low_i),
    .fault_i      (supply_fault),
    .button_i     (button_hold),
    .rst_i        (rst_drive_low_o)
);

// File: tb/reset_supervisor_bench.sv
`timescale 1ns/1ps
module reset_supervisor_bench;
    localparam int G  = 4;
    localparam int DB = 6;
    localparam int TR = 20;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic arst_n     = 1'b0;
    logic supply_low = 1'b0;
    logic man_n      = 1'b1;
    logic rst_drive_low;
    logic rst_n;

    reset_supervisor #(
        .GLITCH_CYCLES   (G),
        .DEBOUNCE_CYCLES (DB),
        .TREC_CYCLES     (TR)
    ) u_reset_supervisor (
        .clk             (clk),
        .arst_n          (arst_n),
        .supply_low_i    (supply_low),
        .man_rst_ni      (man_n),
        .rst_drive_low_o (rst_drive_low),
        .rst_n_o         (rst_n)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        logic  lvl;
        string req;
    } exp_t;

    exp_t q[$];
    int   checks    = 0;
    int   fails     = 0;
    logic prev_n    = 1'b0;
    bit   mon_en    = 1'b0;
    int   last_fall = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_edge(input int at, input logic lvl, input string req);
        exp_t e;
        e.at  = at;
        e.lvl = lvl;
        e.req = req;
        q.push_back(e);
    endtask

    // Monitor: every rst_n edge must match the oldest expected item.
    always @(negedge clk) begin
        if (mon_en && (rst_n !== prev_n)) begin
            if (q.size() == 0) begin
                check(1'b0, "R11", "unexpected rst_n edge at cycle", cyc, -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                check((cyc == e.at) && (rst_n === e.lvl), e.req,
                      "rst_n edge cycle", cyc, e.at);
                check(rst_drive_low === ~rst_n, "R10", "drive_low vs rst_n",
                      int'(rst_drive_low), int'(~rst_n));
            end
            if (rst_n === 1'b0) begin
                last_fall = cyc;
            end else if (cyc != 0) begin
                check((cyc - last_fall) >= TR, "R12", "assertion length",
                      cyc - last_fall, TR);
            end
            prev_n = rst_n;
        end
    end

    task automatic sup_pulse(input int len, output int c_on, output int c_off);
        @(negedge clk);
        supply_low = 1'b1;
        c_on = cyc;
        repeat (len) @(negedge clk);
        supply_low = 1'b0;
        c_off = cyc;
    endtask

    task automatic man_set(input logic v, output int c);
        @(negedge clk);
        man_n = v;
        c = cyc;
    endtask

    task automatic sup_set(input logic v, output int c);
        @(negedge clk);
        supply_low = v;
        c = cyc;
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R11 watchdog expired: actual %0d expected %0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        int c_on;
        int c_off;
        int c2_on;
        int c2_off;
        int c;

        // R1 / R10: reset state during local initialisation
        repeat (3) @(negedge clk);
        check(rst_n === 1'b0, "R1", "rst_n during init", int'(rst_n), 0);
        check(rst_drive_low === 1'b1, "R10", "drive_low during init",
              int'(rst_drive_low), 1);
        arst_n = 1'b1;
        c      = cyc;
        prev_n = rst_n;
        mon_en = 1'b1;
        expect_edge(c + TR, 1'b1, "R1");
        wait_idle();

        // R3: dip one sample short of the filter length
        sup_pulse(G - 1, c_on, c_off);
        repeat (G + 8) @(negedge clk);
        check(rst_n === 1'b1, "R3", "rst_n after short dip", int'(rst_n), 1);

        // R2 / R4: minimum qualifying dip
        sup_pulse(G, c_on, c_off);
        expect_edge(c_on + G + 3, 1'b0, "R2");
        expect_edge(c_off + TR + 3, 1'b1, "R4");
        wait_idle();

        // R5: second qualified dip during the hold restarts the count
        sup_pulse(G + 2, c_on, c_off);
        expect_edge(c_on + G + 3, 1'b0, "R2");
        repeat (5) @(negedge clk);
        sup_pulse(G + 1, c2_on, c2_off);
        expect_edge(c2_off + TR + 3, 1'b1, "R5");
        while (cyc < c_off + TR + 4) @(negedge clk);
        check(rst_n === 1'b0, "R5", "rst_n at undisturbed release time",
              int'(rst_n), 0);
        wait_idle();

        // R3: short dip during the hold does not move the release
        sup_pulse(G + 2, c_on, c_off);
        expect_edge(c_on + G + 3, 1'b0, "R2");
        expect_edge(c_off + TR + 3, 1'b1, "R3");
        repeat (5) @(negedge clk);
        sup_pulse(G - 1, c2_on, c2_off);
        wait_idle();

        // R7: button bounce and a press one sample short
        for (int i = 0; i < 4; i++) begin
            man_set(1'b0, c);
            @(negedge clk);
            man_set(1'b1, c);
            @(negedge clk);
        end
        man_set(1'b0, c);
        repeat (DB - 2) @(negedge clk);
        man_set(1'b1, c);
        repeat (DB + TR) @(negedge clk);
        check(rst_n === 1'b1, "R7", "rst_n after bounce", int'(rst_n), 1);

        // R6 / R8: clean press, bouncy release
        man_set(1'b0, c);
        expect_edge(c + DB + 3, 1'b0, "R6");
        repeat (30) @(negedge clk);
        check(rst_n === 1'b0, "R6", "rst_n while button held", int'(rst_n), 0);
        man_set(1'b1, c);
        @(negedge clk);
        man_set(1'b0, c);
        @(negedge clk);
        man_set(1'b1, c);
        expect_edge(c + DB + TR + 2, 1'b1, "R8");
        wait_idle();

        // R9: supply dip inside a button press
        man_set(1'b0, c);
        expect_edge(c + DB + 3, 1'b0, "R6");
        repeat (12) @(negedge clk);
        sup_pulse(G + 3, c_on, c_off);
        repeat (30) @(negedge clk);
        check(rst_n === 1'b0, "R9", "rst_n with button still held",
              int'(rst_n), 0);
        man_set(1'b1, c);
        expect_edge(c + DB + TR + 2, 1'b1, "R9");
        wait_idle();

        // R9: button press inside a long supply fault
        sup_set(1'b1, c);
        expect_edge(c + G + 3, 1'b0, "R2");
        repeat (10) @(negedge clk);
        man_set(1'b0, c);
        repeat (15) @(negedge clk);
        man_set(1'b1, c);
        repeat (40) @(negedge clk);
        check(rst_n === 1'b0, "R9", "rst_n with supply still low",
              int'(rst_n), 0);
        sup_set(1'b0, c);
        expect_edge(c + TR + 3, 1'b1, "R9");
        wait_idle();

        // R11: long idle, no spurious pulse
        repeat (3 * TR) @(negedge clk);
        check(rst_n === 1'b1, "R11", "rst_n after long idle", int'(rst_n), 1);
        check(rst_drive_low === 1'b0, "R11", "drive_low after long idle",
              int'(rst_drive_low), 0);

        check(q.size() == 0, "R11", "pending expected edges", q.size(), 0);
        summary();
        $finish;
    end
endmodule